// File: doc/BRIEF.md
# Handshaked Peripheral Bus Register Interface

This block is the register-access front end of a peripheral that sits on an asynchronous 8-bit processor bus. The bus uses a strobe and acknowledge handshake. The processor asserts chip-select and data-strobe, and may also assert an interrupt-acknowledge strobe. All three strobes are active low and pass through a two-flop synchronizer. The block makes its decisions on falling clock edges, and it answers each access with an active-low acknowledge. When the cycle ends, the acknowledge is driven high for one clock period and then released to high impedance, which is modelled here as a separate output enable.

Register accesses select one of 32 registers through a 5-bit address. A write loads the incoming data byte, and a read drives the register onto the bus. An interrupt-acknowledge cycle drives a vector instead. Sixteen request lines feed a pending set: lines 0 to 7 stand for internal sources and lines 8 to 15 for external ones. An active-low interrupt request is asserted while any bit is pending. The vector takes its upper nibble from a programmable base and its lower nibble from the highest pending channel. Delivering a vector clears that channel's pending bit.

Top module: `pbus_slave`

## Requirements
- R1: After reset, `dtack_oe_o` and `dat_oe_o` are 0, `irq_no` is 1, and every register reads back as 0x00.
- R2: A write cycle (`cs_ni`=0, `ds_ni`=0, `rw_i`=0) loads `dat_i` into register `rs_i` on the falling edge at which the acknowledge is asserted. `dat_oe_o` stays 0 for the whole cycle.
- R3: A read cycle (`rw_i`=1) drives the addressed register on `dat_o` with `dat_oe_o`=1 while the acknowledge is asserted.
- R4: `dtack_no` goes low with `dtack_oe_o`=1 on the third falling edge after both qualifying strobes go low. Two edges are spent in the synchronizer and one in the decision.
- R5: After either qualifying strobe is negated, the third falling edge drives `dtack_no` high with `dtack_oe_o` still 1, and clears `dat_oe_o`. The next falling edge clears `dtack_oe_o`.
- R6: Only one acknowledge is given per cycle. Once a cycle has been acknowledged, no new acknowledge and no write occur until chip-select, data-strobe and interrupt-acknowledge have all been seen negated together.
- R7: A high `src_req_i[n]` at a falling edge sets pending bit n. `irq_no` is 0 exactly while at least one bit is pending.
- R8: An interrupt-acknowledge cycle (`iack_ni`=0, `ds_ni`=0, `cs_ni`=1) drives `dat_o` = {register 31 bits 7:4, n}, where n is the highest pending channel. It sets `dat_oe_o`=1, clears pending bit n, and writes no register.
- R9: An interrupt-acknowledge cycle with nothing pending returns {register 31 bits 7:4, 4'h0} and leaves the pending set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; decisions on falling edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select, active low |
| ds_ni | input | 1 | Data-strobe, active low |
| iack_ni | input | 1 | Interrupt-acknowledge strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| rs_i | input | 5 | Register select |
| dat_i | input | 8 | Data from processor |
| src_req_i | input | 16 | Interrupt request lines, 0-7 internal, 8-15 external |
| dat_o | output | 8 | Data or vector to processor |
| dat_oe_o | output | 1 | Data bus drive enable |
| dtack_no | output | 1 | Acknowledge, active low |
| dtack_oe_o | output | 1 | Acknowledge drive enable |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
A stuck or mis-sequenced handshake state shows up at the port within one access. The acknowledge arrives on the wrong edge, fails to release, or appears a second time in the same cycle. A wrong register or address decode appears on the first read of the affected location, so a full write-then-read sweep of all 32 addresses exposes it. A bad priority encoder or pending-clear path shows as a wrong low nibble, or as `irq_no` staying low, in the vector sequence returned after loading a request pattern. Each pattern is drained one acknowledge per channel.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_HI} bus_st_e;
  typedef enum logic [1:0] {CY_WR, CY_RD, CY_IA} cyc_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/pbus_regs.sv
module pbus_regs #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int BW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [BW-1:0] base_o
);
  localparam int NREG = 1 << AW;

  logic [NREG-1:0][DW-1:0] mem_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
  // vector base lives in the top nibble of the last register
  assign base_o  = mem_q[NREG-1][DW-1 -: BW];

  a_r2_write_only_on_we: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/pbus_irq.sv
module pbus_irq #(
  parameter int NSRC = 16,
  parameter int CW   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] req_i,
  input  logic            take_i,
  output logic [CW-1:0]   chan_o,
  output logic            any_o
);
  logic [NSRC-1:0] pend_q, clr;

  always_comb begin
    chan_o = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend_q[i]) chan_o = CW'(i);
  end

  assign any_o = |pend_q;

  always_comb begin
    clr = '0;
    if (take_i && any_o) clr[chan_o] = 1'b1;
  end

  // a new request wins over a same-edge clear
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | req_i;
  end

  a_r8_single_clear: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0(clr));
  a_r8_pending_dropped: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (take_i && any_o && !req_i[chan_o]) |=> !pend_q[$past(chan_o)]);
  a_r7_request_pends: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> any_o);
  a_r9_idle_take_noop: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (take_i && !any_o && req_i == '0) |=> !any_o);
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 5,
  parameter int NSRC = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            ds_ni,
  input  logic            iack_ni,
  input  logic            rw_i,
  input  logic [AW-1:0]   rs_i,
  input  logic [DW-1:0]   dat_i,
  input  logic [NSRC-1:0] src_req_i,
  output logic [DW-1:0]   dat_o,
  output logic            dat_oe_o,
  output logic            dtack_no,
  output logic            dtack_oe_o,
  output logic            irq_no
);
  localparam int CW = $clog2(NSRC);
  localparam int BW = DW - CW;

  logic cs_s, ds_s, iack_s;
  logic cyc_w, all_off_w, start_w, ack_w;
  cyc_e kind_w, kind_q;
  bus_st_e st_q;
  logic armed_q, dat_oe_q;
  logic [DW-1:0] dat_q, rdata;
  logic [BW-1:0] base;
  logic [CW-1:0] chan;
  logic any_pend;

  pbus_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (~{iack_ni, ds_ni, cs_ni}),
    .q_o    ({iack_s, ds_s, cs_s})
  );

  assign cyc_w     = ds_s & (cs_s | iack_s);
  assign all_off_w = ~cs_s & ~ds_s & ~iack_s;
  assign start_w   = (st_q == ST_IDLE) && cyc_w && armed_q;
  assign kind_w    = (iack_s && !cs_s) ? CY_IA : (rw_i ? CY_RD : CY_WR);
  assign ack_w     = (st_q == ST_ACK);

  pbus_regs #(.DW(DW), .AW(AW), .BW(BW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (start_w && kind_w == CY_WR),
    .addr_i  (rs_i),
    .wdata_i (dat_i),
    .rdata_o (rdata),
    .base_o  (base)
  );

  pbus_irq #(.NSRC(NSRC), .CW(CW)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (src_req_i),
    .take_i (start_w && kind_w == CY_IA),
    .chan_o (chan),
    .any_o  (any_pend)
  );

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      armed_q  <= 1'b1;
      dat_oe_q <= 1'b0;
      dat_q    <= '0;
      kind_q   <= CY_WR;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_w) begin
            st_q     <= ST_ACK;
            armed_q  <= 1'b0;
            kind_q   <= kind_w;
            dat_oe_q <= (kind_w != CY_WR);
            if (kind_w == CY_IA) dat_q <= {base, chan};
            else if (kind_w == CY_RD) dat_q <= rdata;
          end else if (all_off_w) begin
            armed_q <= 1'b1;
          end
        end
        ST_ACK: begin
          if (!cyc_w) begin
            st_q     <= ST_HI;
            dat_oe_q <= 1'b0;
          end
        end
        ST_HI:   st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dat_o      = dat_q;
  assign dat_oe_o   = dat_oe_q;
  assign dtack_no   = ~ack_w;
  assign dtack_oe_o = (st_q != ST_IDLE);
  assign irq_no     = ~any_pend;

  a_r2_no_drive_on_write: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (kind_q == CY_WR) |-> !dat_oe_o);
  a_r3_data_with_ack: assert property (@(negedge clk_i) disable iff (!rst_ni)
    dat_oe_o |-> (dtack_oe_o && !dtack_no));
  a_r5_release_after_high: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (dtack_oe_o && dtack_no) |=> !dtack_oe_o);
  a_r6_one_ack_per_cycle: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(ack_w) |-> $past(armed_q));
endmodule

// File: tb/sim_pbus_slave.sv
module sim_pbus_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ds_n = 1'b1, iack_n = 1'b1, rw = 1'b1;
  logic [4:0] rs = '0;
  logic [7:0] din = '0;
  logic [15:0] src = '0;
  logic [7:0] dout;
  logic dat_oe, dtack_n, dtack_oe, irq_n;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pbus_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ds_ni(ds_n), .iack_ni(iack_n),
    .rw_i(rw), .rs_i(rs), .dat_i(din), .src_req_i(src),
    .dat_o(dout), .dat_oe_o(dat_oe), .dtack_no(dtack_n), .dtack_oe_o(dtack_oe),
    .irq_no(irq_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction

  // one complete access; ia selects an interrupt-acknowledge cycle
  task automatic access(input bit rd, input bit ia, input logic [4:0] a,
                        input logic [7:0] d, input string tag, output logic [7:0] q);
    int lat;
    @(posedge clk);
    rs = a; rw = rd; din = d;
    if (ia) iack_n = 1'b0; else cs_n = 1'b0;
    ds_n = 1'b0;
    lat = 0;
    do begin @(posedge clk); lat++; end while (!(dtack_oe && !dtack_n) && lat < 10);
    chk("R4 ack latency", lat, 3);
    chk(tag, int'(dat_oe), (rd || ia) ? 1 : 0);
    q = dout;
    ds_n = 1'b1;
    repeat (2) @(posedge clk);
    chk("R5 ack held low", int'(dtack_n), 0);
    @(posedge clk);
    chk("R5 ack driven high", int'({dtack_oe, dtack_n}), 3);
    chk("R5 data released", int'(dat_oe), 0);
    @(posedge clk);
    chk("R5 ack tristated", int'(dtack_oe), 0);
    cs_n = 1'b1; iack_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic pulse_src(input logic [15:0] m);
    @(posedge clk); src = m;
    @(posedge clk); src = '0;
  endtask

  task automatic drain(input logic [15:0] m, input logic [3:0] base);
    logic [7:0] v;
    logic [15:0] left;
    left = m;
    pulse_src(m);
    chk("R7 irq asserted", int'(irq_n), (m != 0) ? 0 : 1);
    for (int c = 15; c >= 0; c--) begin
      if (left[c]) begin
        access(1'b1, 1'b1, 5'd0, 8'h00, "R8 vector drive", v);
        chk("R8 vector", int'(v), int'({base, 4'(c)}));
        left[c] = 1'b0;
        chk("R7 irq tracks pending", int'(irq_n), (left != 0) ? 0 : 1);
      end
    end
  endtask

  initial begin
    logic [7:0] q;
    #3;
    chk("R1 ack oe", int'(dtack_oe), 0);
    chk("R1 data oe", int'(dat_oe), 0);
    chk("R1 irq", int'(irq_n), 1);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 32; i++) begin
      access(1'b1, 1'b0, 5'(i), 8'h00, "R3 read drive", q);
      chk("R1 reset register", int'(q), 0);
    end
    for (int i = 0; i < 32; i++) access(1'b0, 1'b0, 5'(i), pat(i), "R2 no drive on write", q);
    for (int i = 0; i < 32; i++) begin
      access(1'b1, 1'b0, 5'(i), 8'h00, "R3 read drive", q);
      chk("R2 R3 readback", int'(q), int'(pat(i)));
    end

    // R6: a cycle ended by chip-select alone must not re-acknowledge
    access(1'b0, 1'b0, 5'd3, 8'h11, "R2 no drive on write", q);
    @(posedge clk);
    rs = 5'd3; rw = 1'b0; din = 8'h22; cs_n = 1'b0; ds_n = 1'b0;
    repeat (4) @(posedge clk);
    chk("R6 first ack", int'(dtack_n), 0);
    cs_n = 1'b1;
    repeat (5) @(posedge clk);
    chk("R6 released", int'(dtack_oe), 0);
    din = 8'h33; cs_n = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk);
      chk("R6 no second ack", int'(dtack_oe), 0);
    end
    cs_n = 1'b1; ds_n = 1'b1;
    repeat (4) @(posedge clk);
    access(1'b1, 1'b0, 5'd3, 8'h00, "R3 read drive", q);
    chk("R6 no second write", int'(q), 8'h22);

    // interrupt vectors with base 0xB in register 31
    access(1'b0, 1'b0, 5'd31, 8'hB7, "R2 no drive on write", q);
    access(1'b1, 1'b1, 5'd0, 8'h00, "R9 vector drive", q);
    chk("R9 empty vector", int'(q), 8'hB0);
    chk("R9 nothing pending", int'(irq_n), 1);
    drain(16'hFFFF, 4'hB);
    drain(16'hA5C3, 4'hB);
    for (int c = 0; c < 16; c++) drain(16'(1 << c), 4'hB);
    access(1'b1, 1'b0, 5'd31, 8'h00, "R3 read drive", q);
    chk("R8 no register write on vector", int'(q), 8'hB7);
    access(1'b0, 1'b0, 5'd31, 8'h4F, "R2 no drive on write", q);
    drain(16'h0120, 4'h4);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule